// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of which operating mode a small processor is in (full-speed active, low-speed subactive, standby or stop) and runs the sequences that move it from one mode to another. Software programs a 4-bit mode-control word and then issues a sleep strobe, which corresponds to the processor executing its stop or standby instruction. The block combines that strobe with the low-speed flag, the direct-transfer flag and the current mode to pick the next mode. It drives the main oscillator enable and exposes the stabilization down-counter.

There is one special path from subactive back to active. It is armed by clearing the low-speed flag and setting the direct-transfer flag. The next sleep strobe then starts a transfer instead of a sleep. The transfer first waits for the next interrupt-frame strobe from the timebase. It then runs a fixed oscillator settling interval and only after that enters active mode. The stop mode has two exits, and the RAM-enable flag shows which one was taken. A stop-cancel pulse sets the flag to 1. Reset clears it to 0.

Reset is asynchronous. Its release is synchronised by a flop chain, and after that the block resumes in active mode with the control word cleared. A restart request tells the core to start fetching from address zero.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_ni is low, and without any clock edge, the outputs are: mode_o=00, active_o=1, osc_en_o=1, ram_en_o=0, mcw_o=0, stab_cnt_o=0 and restart_o=1. Internal release happens SYNC_STAGES rising edges after rst_ni rises. restart_o stays high through the first cycle after that release and then drops.
- R2: The mode codes are 00 active, 01 subactive, 10 standby and 11 stop. From active, a sleep strobe with sleep_stop_i=1 enters stop. With sleep_stop_i=0 it enters subactive if mcw bit 0 (low-speed) is 1, and standby if bit 0 is 0. osc_en_o is low in subactive, standby and stop and high in active.
- R3: mcw bit 3 (direct-transfer) reads 0 in every cycle with mode 00. A write of 1 to that bit while active has no effect, and the bit is cleared on the edge that enters active.
- R4: A write of 1 to mcw bit 3 is accepted only in subactive; in standby or stop it leaves the bit unchanged. Bit 0 is written in any mode. Bits 2:1 always read 0.
- R5: In subactive, a sleep strobe with mcw bit 0 at 0 and bit 3 at 1 starts a direct transfer. The mode stays 01 and osc_en_o stays 0 until a frame strobe arrives in a later cycle. A frame strobe in the same cycle as the sleep strobe is not counted. If bit 3 is 1 but bit 0 is also 1, the strobe sleeps normally.
- R6: The edge that samples the transfer's frame strobe loads stab_cnt_o with STAB_CYC and raises osc_en_o. The counter then decreases by one per edge. Mode 00 appears on the edge at which it reaches zero, STAB_CYC edges after the frame edge.
- R7: In stop, a wake_i pulse sets ram_en_o=1, raises osc_en_o and loads the counter while the mode stays 11. STAB_CYC edges later the mode is 00, and restart_o is high for exactly that first active cycle.
- R8: wake_i has no effect on mode_o, osc_en_o, stab_cnt_o or ram_en_o in active, subactive or standby.
- R9: ram_en_o holds at 1 after a stop cancel until reset. Reset at any moment, including partway through a transfer, returns every output to its R1 values at once.
- R10: A frame strobe outside a pending transfer has no effect on mode_o, osc_en_o or stab_cnt_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcw_wr_i | input | 1 | Write strobe for the mode-control word |
| mcw_wdata_i | input | 4 | Write data: bit 3 direct-transfer, bit 0 low-speed |
| sleep_i | input | 1 | One-cycle stop/standby instruction strobe |
| sleep_stop_i | input | 1 | Qualifies sleep_i: 1 stop, 0 standby |
| frame_i | input | 1 | One-cycle interrupt-frame strobe from the timebase |
| wake_i | input | 1 | One-cycle stop-cancel pulse |
| mode_o | output | 2 | Current mode code |
| active_o | output | 1 | High when the mode is active |
| osc_en_o | output | 1 | Main oscillator enable |
| stab_cnt_o | output | $clog2(STAB_CYC+1) | Stabilization down-counter value |
| restart_o | output | 1 | Request to restart execution at address zero |
| ram_en_o | output | 1 | RAM-enable status flag |
| mcw_o | output | 4 | Read-back of the mode-control word |

## Verification
The sharpest coincidence is a sleep strobe and a frame strobe landing in the same cycle while a direct transfer is armed. The frame belongs to the period before the transfer began, so it must not shorten the wait. The bench drives both pulses in one cycle. It then confirms that the oscillator stays off and the counter stays at zero for several more cycles, and that active mode comes exactly STAB_CYC edges after the next frame strobe. A second coincidence is an asynchronous reset during the stabilization count. The bench checks this between clock edges and expects every output back at its reset value.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      MODE_ACT  = 2'd0,
      MODE_SUB  = 2'd1,
      MODE_SBY  = 2'd2,
      MODE_STOP = 2'd3
   } lpm_mode_e;

   typedef enum logic [2:0] {
      ST_ACT   = 3'd0,
      ST_SUB   = 3'd1,
      ST_SBY   = 3'd2,
      ST_STOP  = 3'd3,
      ST_XWAIT = 3'd4,
      ST_XSTAB = 3'd5,
      ST_WSTAB = 3'd6
   } lpm_state_e;

   localparam int unsigned MCW_W      = 4;
   localparam int unsigned MCW_DT_BIT = 3;
   localparam int unsigned MCW_LS_BIT = 0;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   output logic srst_no
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpm_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign srst_no = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
   parameter int unsigned LOAD = 16,
   parameter int unsigned W    = $clog2(LOAD + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);

   generate
      if (LOAD < 1) begin : g_bad_load
         $error("lpm_stab_cnt: LOAD must be at least 1");
      end
      if (LOAD == 1) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     flag_q <= 1'b0;
            else if (load_i) flag_q <= 1'b1;
            else             flag_q <= 1'b0;
         end
         assign cnt_o  = W'(flag_q);
         assign last_o = flag_q;
      end else begin : g_down
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            cnt_q <= '0;
            else if (load_i)        cnt_q <= W'(LOAD);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign cnt_o  = cnt_q;
         assign last_o = (cnt_q == W'(1));
      end
   endgenerate

endmodule

// File: rtl/lpm_mcw.sv
module lpm_mcw
   import lpm_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [MCW_W-1:0] wdata_i,
   input  logic             in_sub_i,
   input  logic             act_next_i,
   input  logic             wake_take_i,
   output logic [MCW_W-1:0] mcw_o,
   output logic             lson_o,
   output logic             dton_o,
   output logic             ram_en_o
);

   logic lson_q, dton_q, ram_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lson_q <= 1'b0;
      end else if (wr_i) begin
         lson_q <= wdata_i[MCW_LS_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dton_q <= 1'b0;
      end else if (act_next_i) begin
         dton_q <= 1'b0;
      end else if (wr_i && (!wdata_i[MCW_DT_BIT] || in_sub_i)) begin
         dton_q <= wdata_i[MCW_DT_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ram_q <= 1'b0;
      else if (wake_take_i) ram_q <= 1'b1;
   end

   always_comb begin
      mcw_o             = '0;
      mcw_o[MCW_DT_BIT] = dton_q;
      mcw_o[MCW_LS_BIT] = lson_q;
   end

   assign lson_o   = lson_q;
   assign dton_o   = dton_q;
   assign ram_en_o = ram_q;

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      sleep_i,
   input  logic      sleep_stop_i,
   input  logic      frame_i,
   input  logic      wake_i,
   input  logic      lson_i,
   input  logic      dton_i,
   input  logic      cnt_last_i,
   output logic      load_o,
   output logic      act_next_o,
   output logic      in_sub_o,
   output logic      wake_take_o,
   output logic      osc_en_o,
   output logic      restart_o,
   output lpm_mode_e mode_o
);

   lpm_state_e st_q, st_d;
   logic       restart_q;
   logic       direct_armed;

   assign direct_armed = !lson_i && dton_i;

   always_comb begin
      st_d        = st_q;
      load_o      = 1'b0;
      wake_take_o = 1'b0;
      unique case (st_q)
         ST_ACT: begin
            if (sleep_i) begin
               if (sleep_stop_i) st_d = ST_STOP;
               else if (lson_i)  st_d = ST_SUB;
               else              st_d = ST_SBY;
            end
         end
         ST_SUB: begin
            if (sleep_i) begin
               if (direct_armed)      st_d = ST_XWAIT;
               else if (sleep_stop_i) st_d = ST_STOP;
               else                   st_d = ST_SBY;
            end
         end
         ST_SBY: st_d = ST_SBY;
         ST_STOP: begin
            if (wake_i) begin
               st_d        = ST_WSTAB;
               load_o      = 1'b1;
               wake_take_o = 1'b1;
            end
         end
         ST_XWAIT: begin
            if (frame_i) begin
               st_d   = ST_XSTAB;
               load_o = 1'b1;
            end
         end
         ST_XSTAB, ST_WSTAB: begin
            if (cnt_last_i) st_d = ST_ACT;
         end
         default: st_d = ST_ACT;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_ACT;
         restart_q <= 1'b1;
      end else begin
         st_q      <= st_d;
         restart_q <= (st_q == ST_WSTAB) && cnt_last_i;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_ACT:                     mode_o = MODE_ACT;
         ST_SUB, ST_XWAIT, ST_XSTAB: mode_o = MODE_SUB;
         ST_SBY:                     mode_o = MODE_SBY;
         default:                    mode_o = MODE_STOP;
      endcase
   end

   assign act_next_o = (st_d == ST_ACT);
   assign in_sub_o   = (st_q == ST_SUB);
   assign osc_en_o   = (st_q == ST_ACT) || (st_q == ST_XSTAB) || (st_q == ST_WSTAB);
   assign restart_o  = restart_q;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter  int unsigned STAB_CYC    = 16,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW          = $clog2(STAB_CYC + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mcw_wr_i,
   input  logic [MCW_W-1:0] mcw_wdata_i,
   input  logic             sleep_i,
   input  logic             sleep_stop_i,
   input  logic             frame_i,
   input  logic             wake_i,
   output logic [1:0]       mode_o,
   output logic             active_o,
   output logic             osc_en_o,
   output logic [CW-1:0]    stab_cnt_o,
   output logic             restart_o,
   output logic             ram_en_o,
   output logic [MCW_W-1:0] mcw_o
);

   generate
      if (STAB_CYC < 1) begin : g_bad_stab
         $error("lpm_ctrl: STAB_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lpm_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      srst_n;
   logic      load, act_next, in_sub, wake_take, cnt_last;
   logic      lson, dton;
   lpm_mode_e mode;

   lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk_i   (clk_i),
      .arst_ni (rst_ni),
      .srst_no (srst_n)
   );

   lpm_stab_cnt #(.LOAD(STAB_CYC), .W(CW)) u_stab_cnt (
      .clk_i  (clk_i),
      .rst_ni (srst_n),
      .load_i (load),
      .cnt_o  (stab_cnt_o),
      .last_o (cnt_last)
   );

   lpm_mcw u_mcw (
      .clk_i       (clk_i),
      .rst_ni      (srst_n),
      .wr_i        (mcw_wr_i),
      .wdata_i     (mcw_wdata_i),
      .in_sub_i    (in_sub),
      .act_next_i  (act_next),
      .wake_take_i (wake_take),
      .mcw_o       (mcw_o),
      .lson_o      (lson),
      .dton_o      (dton),
      .ram_en_o    (ram_en_o)
   );

   lpm_mode_fsm u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (srst_n),
      .sleep_i      (sleep_i),
      .sleep_stop_i (sleep_stop_i),
      .frame_i      (frame_i),
      .wake_i       (wake_i),
      .lson_i       (lson),
      .dton_i       (dton),
      .cnt_last_i   (cnt_last),
      .load_o       (load),
      .act_next_o   (act_next),
      .in_sub_o     (in_sub),
      .wake_take_o  (wake_take),
      .osc_en_o     (osc_en_o),
      .restart_o    (restart_o),
      .mode_o       (mode)
   );

   assign mode_o   = mode;
   assign active_o = (mode == MODE_ACT);

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int unsigned STAB_CYC = 16,
   parameter int unsigned CW       = $clog2(STAB_CYC + 1)
) (
   input logic          clk_i,
   input logic          srst_ni,
   input logic [1:0]    mode_i,
   input logic          active_i,
   input logic          osc_en_i,
   input logic [CW-1:0] stab_cnt_i,
   input logic          restart_i,
   input logic          ram_en_i,
   input logic [3:0]    mcw_i,
   input logic          sleep_i,
   input logic          wake_i
);

   int unsigned run_q;

   always_ff @(posedge clk_i or negedge srst_ni) begin
      if (!srst_ni)                  run_q <= 0;
      else if (osc_en_i && !active_i) run_q <= run_q + 1;
      else                           run_q <= 0;
   end

   p_active_osc_r2: assert property (@(posedge clk_i) disable iff (!srst_ni)
      active_i |-> osc_en_i);

   p_sby_osc_off_r2: assert property (@(posedge clk_i) disable iff (!srst_ni)
      (mode_i == 2'd2) |-> !osc_en_i);

   p_active_no_direct_r3: assert property (@(posedge clk_i) disable iff (!srst_ni)
      (mode_i == 2'd0) |-> !mcw_i[3]);

   p_direct_set_sub_r4: assert property (@(posedge clk_i) disable iff (!srst_ni)
      $rose(mcw_i[3]) |-> ($past(mode_i) == 2'd1));

   p_xfer_hold_r5: assert property (@(posedge clk_i) disable iff (!srst_ni)
      (mode_i == 2'd1 && !osc_en_i && sleep_i && mcw_i[3] && !mcw_i[0])
      |=> (mode_i == 2'd1 && !osc_en_i));

   p_stab_window_r6: assert property (@(posedge clk_i) disable iff (!srst_ni)
      run_q <= STAB_CYC);

   p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!srst_ni)
      stab_cnt_i <= CW'(STAB_CYC));

   p_wake_arm_r7: assert property (@(posedge clk_i) disable iff (!srst_ni)
      (mode_i == 2'd3 && !osc_en_i && wake_i) |=> (osc_en_i && ram_en_i && mode_i == 2'd3));

   p_restart_single_r7: assert property (@(posedge clk_i) disable iff (!srst_ni)
      restart_i |=> !restart_i);

   p_ram_only_stop_r8: assert property (@(posedge clk_i) disable iff (!srst_ni)
      (mode_i != 2'd3) |=> $stable(ram_en_i));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.STAB_CYC(STAB_CYC)) u_chk (
   .clk_i      (clk_i),
   .srst_ni    (srst_n),
   .mode_i     (mode_o),
   .active_i   (active_o),
   .osc_en_i   (osc_en_o),
   .stab_cnt_i (stab_cnt_o),
   .restart_i  (restart_o),
   .ram_en_i   (ram_en_o),
   .mcw_i      (mcw_o),
   .sleep_i    (sleep_i),
   .wake_i     (wake_i)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

   localparam int unsigned STAB  = 5;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned CW    = $clog2(STAB + 1);
   localparam time         TCLK  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [3:0]    wdata = '0;
   logic          sleep = 1'b0, sleep_stop = 1'b0, frame = 1'b0, wake = 1'b0;
   logic [1:0]    mode;
   logic          active, osc_en, restart, ram_en;
   logic [CW-1:0] cnt;
   logic [3:0]    mcw;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(TCLK/2) clk = ~clk;

   lpm_ctrl #(.STAB_CYC(STAB), .SYNC_STAGES(SYNC)) u_lpm_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .mcw_wr_i     (wr),
      .mcw_wdata_i  (wdata),
      .sleep_i      (sleep),
      .sleep_stop_i (sleep_stop),
      .frame_i      (frame),
      .wake_i       (wake),
      .mode_o       (mode),
      .active_o     (active),
      .osc_en_o     (osc_en),
      .stab_cnt_o   (cnt),
      .restart_o    (restart),
      .ram_en_o     (ram_en),
      .mcw_o        (mcw)
   );

   task automatic eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(SYNC + 1);
   endtask

   task automatic write_mcw(input logic [3:0] d);
      wr = 1'b1; wdata = d; tick(); wr = 1'b0;
   endtask

   task automatic pulse_sleep(input logic stop_kind);
      sleep = 1'b1; sleep_stop = stop_kind; tick(); sleep = 1'b0; sleep_stop = 1'b0;
   endtask

   task automatic pulse_frame();
      frame = 1'b1; tick(); frame = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1; tick(); wake = 1'b0;
   endtask

   task automatic go_sub();
      write_mcw(4'b0001);
      pulse_sleep(1'b0);
   endtask

   initial begin
      #(TCLK*150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: values while reset is held, between clock edges
      #(TCLK + 3);
      eq("R1 mode in reset", int'(mode), 0);
      eq("R1 active in reset", int'(active), 1);
      eq("R1 osc_en in reset", int'(osc_en), 1);
      eq("R1 ram_en in reset", int'(ram_en), 0);
      eq("R1 mcw in reset", int'(mcw), 0);
      eq("R1 cnt in reset", int'(cnt), 0);
      eq("R1 restart in reset", int'(restart), 1);
      @(negedge clk);
      rst_n = 1'b1;
      tick(SYNC);
      eq("R1 restart first cycle after release", int'(restart), 1);
      tick();
      eq("R1 restart drops", int'(restart), 0);
      eq("R1 mode after release", int'(mode), 0);

      // R3, R4: write sweep in active
      for (int w = 0; w < 16; w++) begin
         write_mcw(4'(w));
         eq("R3 mcw write in active", int'(mcw), w & 1);
      end
      write_mcw(4'b0000);

      // R2: subactive entry, then R4 sweep in subactive
      go_sub();
      eq("R2 mode subactive", int'(mode), 1);
      eq("R2 osc off in subactive", int'(osc_en), 0);
      for (int w = 0; w < 16; w++) begin
         write_mcw(4'(w));
         eq("R4 mcw write in subactive", int'(mcw), w & 9);
      end
      write_mcw(4'b0001);
      pulse_frame();
      eq("R10 frame idle mode", int'(mode), 1);
      eq("R10 frame idle osc", int'(osc_en), 0);
      eq("R10 frame idle cnt", int'(cnt), 0);
      pulse_wake();
      eq("R8 wake in subactive mode", int'(mode), 1);
      eq("R8 wake in subactive osc", int'(osc_en), 0);
      eq("R8 wake in subactive ram", int'(ram_en), 0);
      eq("R8 wake in subactive cnt", int'(cnt), 0);

      // R5, R6: direct transfer with frame delays 1..6
      for (int d = 1; d <= 6; d++) begin
         do_reset();
         go_sub();
         write_mcw(4'b1000);
         pulse_sleep(1'b0);
         eq("R5 transfer holds subactive", int'(mode), 1);
         eq("R5 transfer osc off", int'(osc_en), 0);
         tick(d - 1);
         eq("R5 wait osc off", int'(osc_en), 0);
         pulse_frame();
         eq("R6 counter loaded", int'(cnt), STAB);
         eq("R6 osc on", int'(osc_en), 1);
         eq("R6 still subactive", int'(mode), 1);
         tick(STAB - 1);
         eq("R6 one before end mode", int'(mode), 1);
         eq("R6 one before end cnt", int'(cnt), 1);
         tick();
         eq("R6 active after stabilization", int'(mode), 0);
         eq("R6 counter zero", int'(cnt), 0);
         eq("R3 direct flag cleared", int'(mcw[3]), 0);
         eq("R7 no restart on transfer", int'(restart), 0);
      end

      // R5: sleep and frame in the same cycle
      do_reset();
      go_sub();
      write_mcw(4'b1000);
      sleep = 1'b1; frame = 1'b1; tick(); sleep = 1'b0; frame = 1'b0;
      eq("R5 coincident frame ignored osc", int'(osc_en), 0);
      eq("R5 coincident frame ignored cnt", int'(cnt), 0);
      tick(3);
      eq("R5 still waiting osc", int'(osc_en), 0);
      eq("R5 still waiting mode", int'(mode), 1);
      pulse_frame();
      eq("R6 load after next frame", int'(cnt), STAB);
      tick(STAB);
      eq("R6 active after next frame", int'(mode), 0);

      // R5: both flags set sleeps normally
      do_reset();
      go_sub();
      write_mcw(4'b1001);
      pulse_sleep(1'b0);
      eq("R5 low-speed set blocks transfer", int'(mode), 2);

      // R2: standby from active
      do_reset();
      pulse_sleep(1'b0);
      eq("R2 standby from active", int'(mode), 2);
      eq("R2 osc off in standby", int'(osc_en), 0);
      pulse_wake();
      eq("R8 wake in standby mode", int'(mode), 2);
      eq("R8 wake in standby ram", int'(ram_en), 0);
      write_mcw(4'b1000);
      eq("R4 direct write in standby", int'(mcw), 0);
      pulse_frame();
      eq("R10 frame in standby", int'(mode), 2);

      // R2: stop and standby from subactive
      do_reset();
      go_sub();
      pulse_sleep(1'b1);
      eq("R2 stop from subactive", int'(mode), 3);
      do_reset();
      go_sub();
      pulse_sleep(1'b0);
      eq("R2 standby from subactive", int'(mode), 2);

      // R7: stop and cancel
      do_reset();
      pulse_wake();
      eq("R8 wake in active mode", int'(mode), 0);
      eq("R8 wake in active ram", int'(ram_en), 0);
      eq("R8 wake in active cnt", int'(cnt), 0);
      pulse_sleep(1'b1);
      eq("R2 stop from active", int'(mode), 3);
      eq("R2 osc off in stop", int'(osc_en), 0);
      write_mcw(4'b1000);
      eq("R4 direct write in stop", int'(mcw), 0);
      pulse_wake();
      eq("R7 still stop", int'(mode), 3);
      eq("R7 osc on", int'(osc_en), 1);
      eq("R7 ram_en set", int'(ram_en), 1);
      eq("R7 counter loaded", int'(cnt), STAB);
      tick(STAB - 1);
      eq("R7 before end mode", int'(mode), 3);
      eq("R7 before end restart", int'(restart), 0);
      tick();
      eq("R7 active", int'(mode), 0);
      eq("R7 restart pulse", int'(restart), 1);
      tick();
      eq("R7 restart one cycle", int'(restart), 0);
      eq("R9 ram_en holds", int'(ram_en), 1);
      pulse_wake();
      eq("R9 ram_en holds after stray wake", int'(ram_en), 1);
      rst_n = 1'b0;
      #1;
      eq("R9 reset clears ram_en", int'(ram_en), 0);
      do_reset();

      // R9: reset partway through a transfer
      go_sub();
      write_mcw(4'b1000);
      pulse_sleep(1'b0);
      pulse_frame();
      tick(2);
      #2;
      rst_n = 1'b0;
      #1;
      eq("R9 mid-transfer reset mode", int'(mode), 0);
      eq("R9 mid-transfer reset osc", int'(osc_en), 1);
      eq("R9 mid-transfer reset cnt", int'(cnt), 0);
      eq("R9 mid-transfer reset mcw", int'(mcw), 0);
      eq("R9 mid-transfer reset restart", int'(restart), 1);
      do_reset();
      eq("R1 mode after second release", int'(mode), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule